// File: doc/BRIEF.md
# UART line status logic

This block holds the eight-bit line status word of a UART with a receive FIFO and drives the line-status interrupt request. The receiver reports each completed character with three error flags (parity, framing, break). The CPU side supplies strobes for a status read, a receive-buffer read, a transmit write and a receive FIFO clear. The transmitter supplies two levels: its holding FIFO is empty, and its shift register is idle. The serial shifters, the baud generator and the data FIFO itself sit outside.

The block keeps one small tag per receive FIFO entry, so error information follows each byte through the queue. A byte's parity, framing and break flags show up in the status word when that byte reaches the head of the queue. Bit 7 stays up while any errored byte is still queued. The transmit side is a three-state machine:
- `TX_IDLE`: nothing is queued or shifting.
- `TX_PEND`: a byte was written and the holding FIFO is not yet drained.
- `TX_SHIFT`: the holding FIFO is empty but the shifter is still sending.

Its transitions are:
- IDLE→PEND on a write.
- PEND→IDLE when the FIFO is empty and the shifter is idle.
- PEND→SHIFT when the FIFO is empty and the shifter is busy.
- SHIFT→PEND on a write.
- SHIFT→IDLE when the FIFO is empty and the shifter is idle.
- PEND stays in PEND on a write.

Status bit layout: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 transmit holding empty, bit 6 transmitter empty, bit 7 errored byte queued. All status bits are registered and change on the clock edge that samples their cause.

Top module: `uart_line_status`

## Requirements
- R1: A synchronous active-low reset gives a status value of 0x60, with `rx_avail` and `lsi_irq` low.
- R2: Bit 0 and `rx_avail` rise on the edge that accepts a completed byte. They stay high while the receive FIFO holds at least one byte, and fall once the last byte is read or the FIFO is cleared.
- R3: A completed byte that arrives while the FIFO holds DEPTH entries, with no receive-buffer read in the same cycle, is dropped and sets bit 1. If a read happens in that cycle, the byte is accepted instead. Bit 1 clears on a status read unless a new overrun happens in the same cycle.
- R4: When a byte becomes head of the queue, its flags are ORed into the status word: parity into bit 2, framing into bit 3, break into bit 4. A byte becomes head when it enters an empty FIFO, or when the byte ahead of it is read. A status read clears bits 2 to 4, and a flag latched in the same cycle wins over the clear.
- R5: Bit 5 falls on the edge after a transmit write. It rises again once the transmitter reports its holding FIFO empty while no write is present.
- R6: Bit 6 is high only in TX_IDLE, which means both the holding FIFO and the shift register have been reported empty since the last write.
- R7: Bit 7 sets when a byte with any error flag is accepted. A status read clears it only if no errored byte is queued at the time of that read.
- R8: A FIFO clear empties the queue and drops all error tags. A byte completing in the same cycle is discarded without an overrun. Bit 7 then falls on the next status read.
- R9: `lsi_irq` equals `lsi_en` AND (bit 1 OR bit 2 OR bit 3 OR bit 4).
- R10: A receive-buffer read while the FIFO is empty has no effect: bit 0 stays low and the other bits are unchanged.
- R11: A clean byte queued behind an errored one raises none of bits 2 to 4 when it reaches the head after those bits were cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_done | input | 1 | Receiver completed a character this cycle |
| rx_par_err | input | 1 | Parity error flag of the completed character |
| rx_frm_err | input | 1 | Framing error flag of the completed character |
| rx_brk | input | 1 | Break flag of the completed character |
| rbr_rd | input | 1 | CPU reads the receive buffer |
| rx_fifo_clr | input | 1 | CPU clears the receive FIFO |
| thr_wr | input | 1 | CPU writes the transmit holding register/FIFO |
| tx_fifo_empty | input | 1 | Transmit holding FIFO is empty (updates on the edge taking a write) |
| tx_shift_idle | input | 1 | Transmit shift register is idle |
| lsr_rd | input | 1 | CPU reads the line status word |
| lsi_en | input | 1 | Line-status interrupt enable |
| lsr | output | 8 | Line status word |
| rx_avail | output | 1 | Receive data available |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
The bench targets these corner cases:
- A byte arriving at a full FIFO, with and without a read in the same cycle. A design that ignores the simultaneous read flags a false overrun and loses the byte.
- A status read that coincides with a new error or overrun. A design that lets the clear win drops that event.
- A clean byte that follows an errored one. A design that keeps the tag of the old head reports stale errors.
- Bit 7 read while errored bytes remain queued. A design that clears it on every read hides queued errors.
- A FIFO clear that coincides with a completing byte, and reads of an empty buffer. Either can corrupt the occupancy count.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PEND  = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_tag_t;

endpackage

// File: rtl/lsr_tag_fifo.sv
module lsr_tag_fifo
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  err_tag_t                     push_tag,
    input  logic                         pop,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overrun,
    output logic                         push_err,
    output logic                         pres,
    output err_tag_t                     pres_tag,
    output logic                         err_none
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    err_tag_t          mem [DEPTH];
    logic [PW-1:0]     rd_ptr;
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_nxt;
    logic [PW-1:0]     wr_nxt;
    logic [CW-1:0]     err_cnt;
    logic              pop_ok;
    logic              push_ok;
    logic              pop_err;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign rd_nxt = ptr_inc(rd_ptr);
    assign wr_nxt = ptr_inc(wr_ptr);

    always_comb begin
        pop_ok   = pop && (count != '0) && !clr;
        push_ok  = push && !clr && ((count != CW'(DEPTH)) || pop_ok);
        overrun  = push && !clr && !push_ok;
        push_err = push_ok && (push_tag != '0);
        pop_err  = pop_ok && (mem[rd_ptr] != '0);
        pres     = 1'b0;
        pres_tag = '0;
        if (push_ok && (count == '0)) begin
            pres     = 1'b1;
            pres_tag = push_tag;
        end else if (pop_ok && (count > CW'(1))) begin
            pres     = 1'b1;
            pres_tag = mem[rd_nxt];
        end else if (pop_ok && push_ok && (count == CW'(1))) begin
            pres     = 1'b1;
            pres_tag = push_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= rd_nxt;
            if (push_ok) wr_ptr <= wr_nxt;
            count   <= count + CW'(push_ok) - CW'(pop_ok);
            err_cnt <= err_cnt + CW'(push_err) - CW'(pop_err);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_tag;
    end

    assign err_none = (err_cnt == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> $stable(count));

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && err_none);
endmodule

// File: rtl/lsr_tx_fsm.sv
module lsr_tx_fsm
    import lsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic tx_fifo_empty,
    input  logic tx_shift_idle,
    output logic thre,
    output logic temt
);
    tx_state_e state_q;
    tx_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (thr_wr) state_d = TX_PEND;
            end
            TX_PEND: begin
                if (thr_wr)              state_d = TX_PEND;
                else if (tx_fifo_empty)  state_d = tx_shift_idle ? TX_IDLE : TX_SHIFT;
            end
            TX_SHIFT: begin
                if (thr_wr)                               state_d = TX_PEND;
                else if (tx_fifo_empty && tx_shift_idle)  state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        thre = 1'b1;
        temt = 1'b0;
        unique case (state_q)
            TX_IDLE:  begin thre = 1'b1; temt = 1'b1; end
            TX_PEND:  begin thre = 1'b0; temt = 1'b0; end
            TX_SHIFT: begin thre = 1'b1; temt = 1'b0; end
            default:  begin thre = 1'b1; temt = 1'b0; end
        endcase
    end

    // R5
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre);

    // R6
    temt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(temt) |-> $past(tx_shift_idle) && $past(tx_fifo_empty));
endmodule

// File: rtl/lsr_rx_flags.sv
module lsr_rx_flags
    import lsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lsr_rd,
    input  logic     overrun,
    input  logic     pres,
    input  err_tag_t pres_tag,
    input  logic     push_err,
    input  logic     err_none,
    output logic     oe,
    output err_tag_t errs,
    output logic     fifo_err
);
    err_tag_t latch_in;

    assign latch_in = pres ? pres_tag : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe       <= 1'b0;
            errs     <= '0;
            fifo_err <= 1'b0;
        end else begin
            oe       <= overrun | (oe & ~lsr_rd);
            errs     <= latch_in | (lsr_rd ? err_tag_t'('0) : errs);
            fifo_err <= push_err | (fifo_err & ~(lsr_rd & err_none));
        end
    end

    // R3
    oe_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !overrun) |=> !oe);

    // R7
    fifo_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err && !err_none) |=> fifo_err);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_done,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       rbr_rd,
    input  logic       rx_fifo_clr,
    input  logic       thr_wr,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_idle,
    input  logic       lsr_rd,
    input  logic       lsi_en,
    output logic [7:0] lsr,
    output logic       rx_avail,
    output logic       lsi_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    err_tag_t        in_tag;
    err_tag_t        pres_tag;
    err_tag_t        errs;
    logic [CW-1:0]   count;
    logic            overrun;
    logic            push_err;
    logic            pres;
    logic            err_none;
    logic            oe;
    logic            fifo_err;
    logic            thre;
    logic            temt;
    logic            dr;

    assign in_tag = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};

    lsr_tag_fifo #(.DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_fifo_clr),
        .push     (rx_done),
        .push_tag (in_tag),
        .pop      (rbr_rd),
        .count    (count),
        .overrun  (overrun),
        .push_err (push_err),
        .pres     (pres),
        .pres_tag (pres_tag),
        .err_none (err_none)
    );

    lsr_rx_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lsr_rd   (lsr_rd),
        .overrun  (overrun),
        .pres     (pres),
        .pres_tag (pres_tag),
        .push_err (push_err),
        .err_none (err_none),
        .oe       (oe),
        .errs     (errs),
        .fifo_err (fifo_err)
    );

    lsr_tx_fsm u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .thr_wr        (thr_wr),
        .tx_fifo_empty (tx_fifo_empty),
        .tx_shift_idle (tx_shift_idle),
        .thre          (thre),
        .temt          (temt)
    );

    assign dr       = (count != '0);
    assign lsr      = {fifo_err, temt, thre, errs.brk, errs.frm, errs.par, oe, dr};
    assign rx_avail = dr;
    assign lsi_irq  = lsi_en & (oe | errs.par | errs.frm | errs.brk);

    // R2
    clear_drops_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |=> !rx_avail);

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !rx_done && !dr) |=> !dr);
endmodule

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
    logic rbr_rd = 0, rx_fifo_clr = 0, thr_wr = 0;
    logic tx_fifo_empty = 1, tx_shift_idle = 1, lsr_rd = 0, lsi_en = 0;
    logic [7:0] lsr;
    logic rx_avail, lsi_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [2:0] mq [D];
    int mcnt;
    bit moe, mb7, mthre, mtemt;
    logic [2:0] mpfb;

    uart_line_status #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rbr_rd(rbr_rd),
        .rx_fifo_clr(rx_fifo_clr), .thr_wr(thr_wr), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_idle(tx_shift_idle), .lsr_rd(lsr_rd), .lsi_en(lsi_en),
        .lsr(lsr), .rx_avail(rx_avail), .lsi_irq(lsi_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_lsr();
        return {mb7, mtemt, mthre, mpfb[2], mpfb[1], mpfb[0], moe, (mcnt != 0)};
    endfunction

    function automatic int err_count();
        int n = 0;
        for (int i = 0; i < mcnt; i++) if (mq[i] != 3'b000) n++;
        return n;
    endfunction

    // One cycle: drive at the falling edge, predict, compare after the rising edge.
    task automatic cyc(input bit done, input logic [2:0] tag, input bit rrd, input bit clr,
                       input bit wr, input bit fe, input bit si, input bit lrd, input bit en,
                       input string rq);
        int ec;
        bit pop, pushok, ovr, pres;
        logic [2:0] ptag;
        rx_done = done; rx_par_err = tag[0]; rx_frm_err = tag[1]; rx_brk = tag[2];
        rbr_rd = rrd; rx_fifo_clr = clr; thr_wr = wr; tx_fifo_empty = fe;
        tx_shift_idle = si; lsr_rd = lrd; lsi_en = en;
        ec = err_count();
        pres = 0; ptag = 3'b000; ovr = 0; pushok = 0;
        if (clr) begin
            mcnt = 0;
        end else begin
            pop = rrd && (mcnt > 0);
            pushok = done && ((mcnt < D) || pop);
            ovr = done && !pushok;
            if (pop) begin
                for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (pushok) begin
                mq[mcnt] = tag;
                mcnt++;
            end
            pres = ((mcnt == 1) && pushok && !pop) || (pop && (mcnt > 0));
            if (pres) ptag = mq[0];
        end
        moe  = ovr | (moe & !lrd);
        mpfb = ptag | (lrd ? 3'b000 : mpfb);
        mb7  = (pushok && (tag != 3'b000)) | (mb7 & !(lrd && (ec == 0)));
        mtemt = !wr && (mtemt || (fe && si));
        mthre = !wr && (mthre || fe);
        @(posedge clk);
        #2;
        chk(rq, "lsr", lsr, exp_lsr());
        chk(rq, "rx_avail", {7'd0, rx_avail}, {7'd0, (mcnt != 0)});
        chk("R9", "lsi_irq", {7'd0, lsi_irq}, {7'd0, en & (moe | (mpfb != 3'b000))});
        @(negedge clk);
    endtask

    task automatic idle(input string rq);
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 0, 1, rq);
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        mcnt = 0; moe = 0; mb7 = 0; mthre = 1; mtemt = 1; mpfb = 3'b000;
        for (int i = 0; i < D; i++) mq[i] = 3'b000;
        lsi_en = 1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "reset lsr", lsr, 8'h60);
        chk("R1", "reset rx_avail", {7'd0, rx_avail}, 8'h00);
        chk("R1", "reset irq", {7'd0, lsi_irq}, 8'h00);
        @(negedge clk);
        rst_n = 1;

        // R2: one clean byte in, then out
        cyc(1, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R2");
        chk("R2", "dr after byte", {7'd0, lsr[0]}, 8'h01);
        cyc(0, 3'b000, 1, 0, 0, 1, 1, 0, 1, "R2");
        chk("R2", "dr after read", {7'd0, lsr[0]}, 8'h00);

        // R10: read of empty buffer
        cyc(0, 3'b000, 1, 0, 0, 1, 1, 0, 1, "R10");
        chk("R10", "empty read lsr", lsr, 8'h60);

        // R4 / R11: errored byte then clean byte
        cyc(1, 3'b001, 0, 0, 0, 1, 1, 0, 1, "R4");
        chk("R4", "parity latched", lsr & 8'h1C, 8'h04);
        cyc(1, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R4");
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 1, 1, "R4");
        cyc(0, 3'b000, 1, 0, 0, 1, 1, 0, 1, "R11");
        chk("R11", "clean head no err", lsr & 8'h1C, 8'h00);
        // R7: bit7 cleared by read now that no errored entry remains
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 1, 1, "R7");
        chk("R7", "bit7 cleared", {7'd0, lsr[7]}, 8'h00);
        cyc(0, 3'b000, 1, 0, 0, 1, 1, 0, 1, "R2");

        // R7: bit7 survives a read while an errored byte is queued
        cyc(1, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R7");
        cyc(1, 3'b110, 0, 0, 0, 1, 1, 0, 1, "R7");
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 1, 1, "R7");
        chk("R7", "bit7 held", {7'd0, lsr[7]}, 8'h01);
        cyc(0, 3'b000, 1, 0, 0, 1, 1, 0, 1, "R4");
        chk("R4", "frm+brk at head", lsr & 8'h1C, 8'h18);

        // R3: fill to depth, overrun, then push with simultaneous read
        for (int i = 0; i < D; i++) cyc(1, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R3");
        cyc(1, 3'b000, 0, 0, 0, 1, 1, 0, 0, "R3");
        chk("R3", "overrun set", {7'd0, lsr[1]}, 8'h01);
        cyc(1, 3'b000, 1, 0, 0, 1, 1, 1, 1, "R3");
        chk("R3", "no overrun with read", {7'd0, lsr[1]}, 8'h00);
        cyc(1, 3'b000, 0, 0, 0, 1, 1, 1, 1, "R3");
        chk("R3", "overrun wins over read", {7'd0, lsr[1]}, 8'h01);

        // R8: clear with simultaneous byte
        cyc(1, 3'b001, 0, 1, 0, 1, 1, 0, 1, "R8");
        chk("R8", "cleared dr", {7'd0, lsr[0]}, 8'h00);
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 1, 1, "R8");
        chk("R8", "bit7 after clear+read", {7'd0, lsr[7]}, 8'h00);

        // R5 / R6: transmit sequence
        cyc(0, 3'b000, 0, 0, 1, 1, 1, 0, 1, "R5");
        chk("R5", "thre after write", lsr & 8'h60, 8'h00);
        cyc(0, 3'b000, 0, 0, 0, 0, 1, 0, 1, "R5");
        cyc(0, 3'b000, 0, 0, 0, 1, 0, 0, 1, "R6");
        chk("R6", "shifting", lsr & 8'h60, 8'h20);
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R6");
        chk("R6", "tx idle", lsr & 8'h60, 8'h60);

        // R9: enable gating
        cyc(1, 3'b100, 0, 0, 0, 1, 1, 0, 0, "R9");
        cyc(0, 3'b000, 0, 0, 0, 1, 1, 0, 1, "R9");
        chk("R9", "irq with break", {7'd0, lsi_irq}, 8'h01);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit d, r, c, w, f, s, l, e;
            logic [2:0] t;
            d = ($urandom % 100) < 35;
            t = (($urandom % 100) < 25) ? 3'($urandom) : 3'b000;
            r = ($urandom % 100) < 30;
            c = ($urandom % 100) < 2;
            w = ($urandom % 100) < 10;
            f = ($urandom % 100) < 50;
            s = ($urandom % 100) < 60;
            l = ($urandom % 100) < 15;
            e = ($urandom % 100) < 70;
            cyc(d, t, r, c, w, f, s, l, e, "R2");
        end
        idle("R2");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule